// File: doc/BRIEF.md
# Register-Array Synchronous FIFO

A single-clock first-in, first-out queue. Its storage is an array of flip-flops. Both data width and depth are parameters, and the depth must be a power of two. An upstream stage offers a word on `datain` and raises `load`. A downstream stage takes the oldest word from `dataout` and raises `extract` to retire it. The oldest word appears on `dataout` through a read multiplexer, so no read cycle is needed. `empty` tells the consumer that no valid word is held. `full` tells the producer to stall.

The write and read pointers each carry one extra wrap bit above the address bits, and both flags come from comparing the two pointers. A load that arrives while the FIFO is full is refused, except when an extract happens in the same cycle. In that case the freed slot is refilled at once and `full` stays high. An extract while empty is ignored. Reset is active low. A parameter selects whether reset acts immediately or at the next rising clock edge. Reset moves only the pointers, and the stored words are kept.

Top module: `flop_fifo`

## Requirements
- R1: While and after reset (`rst_n` low), `empty` is 1, `full` is 0, and both pointers point to slot 0.
- R2: Accepted words leave in the order they were accepted. When `empty` is 0, `dataout` already shows the oldest word, with no read cycle.
- R3: With `full` = 1 and `extract` = 0, a load is ignored. `full` stays 1 and the queue contents stay the same.
- R4: With `full` = 1, `load` = 1 and `extract` = 1, the head is retired and `datain` is appended in the same cycle. `full` stays 1.
- R5: With `empty` = 1, an extract is ignored. `empty` stays 1, unless a load in that cycle is accepted.
- R6: `full` rises on the edge that accepts the DEPTH-th word without a matching extract, and not before.
- R7: `empty` falls one edge after a load into an empty FIFO. It rises on the edge that retires the last word.
- R8: With the FIFO neither empty nor full, a cycle with both `load` and `extract` keeps the occupancy the same while the data still advances.
- R9: Reset does not clear storage. After reset, `dataout` shows whatever slot 0 last held.
- R10: With `ASYNC_RST` = 1, a falling `rst_n` sets `empty` without a clock edge. With `ASYNC_RST` = 0, the reset takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the pointers |
| load | input | 1 | Append `datain` this cycle |
| extract | input | 1 | Retire the head word this cycle |
| datain | input | WIDTH | Word to append |
| dataout | output | WIDTH | Word at the read pointer |
| empty | output | 1 | No valid word held |
| full | output | 1 | All DEPTH slots occupied |

## Verification
Load and extract can fall in the same cycle, and the outcome depends on the state the FIFO is in. When full, both happen and `full` holds. When empty, only the load happens. In between, both pointers advance. A vector table drives this pair in all three states: repeated load-with-extract while full until every word written that way has come out, plus same-cycle pairs while empty and while partly filled. A queue model then judges every `dataout`, `empty` and `full` value. A long run of random load and extract follows, with both reset variants receiving the same stimulus.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    typedef struct packed {
        logic empty;
        logic full;
    } fifo_flags_t;

    typedef struct packed {
        logic wr;
        logic rd;
    } fifo_xfer_t;

    // A load is taken when space exists or a read frees a slot in the same cycle.
    function automatic fifo_xfer_t decide_xfer(input logic load,
                                               input logic extract,
                                               input fifo_flags_t fl);
        fifo_xfer_t x;
        x.rd = extract & ~fl.empty;
        x.wr = load & (~fl.full | extract);
        return x;
    endfunction

endpackage

// File: rtl/fifo_ptr.sv
module fifo_ptr #(
    parameter int AW        = 4,
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    output logic [AW:0] ptr
);

    logic [AW:0] ptr_nxt;

    assign ptr_nxt = adv ? ptr + 1'b1 : ptr;

    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ptr <= '0;
                else        ptr <= ptr_nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) ptr <= '0;
                else        ptr <= ptr_nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/fifo_regs.sv
module fifo_regs #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] slots [DEPTH];

    // No reset on the array: contents survive a pointer reset.
    always_ff @(posedge clk) begin
        if (wr_en) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/flop_fifo.sv
module flop_fifo
    import fifo_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 16,
    parameter int AW        = $clog2(DEPTH),
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             extract,
    input  logic [WIDTH-1:0] datain,
    output logic [WIDTH-1:0] dataout,
    output logic             empty,
    output logic             full
);

    localparam int PW = AW + 1;

    initial begin
        a_depth_pow2: assert (DEPTH == (1 << AW) && AW >= 1)
            else $error("DEPTH must be a power of two at least 2 with AW = log2(DEPTH)");
    end

    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    fifo_flags_t   flags;
    fifo_xfer_t    xfer;

    assign flags.empty = (wptr == rptr);
    assign flags.full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign xfer        = decide_xfer(load, extract, flags);

    fifo_ptr #(.AW(AW), .ASYNC_RST(ASYNC_RST)) u_wptr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (xfer.wr),
        .ptr  (wptr)
    );

    fifo_ptr #(.AW(AW), .ASYNC_RST(ASYNC_RST)) u_rptr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (xfer.rd),
        .ptr  (rptr)
    );

    fifo_regs #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_regs (
        .clk  (clk),
        .wr_en(xfer.wr),
        .waddr(wptr[AW-1:0]),
        .wdata(datain),
        .raddr(rptr[AW-1:0]),
        .rdata(dataout)
    );

    assign empty = flags.empty;
    assign full  = flags.full;

    // R3: refused load leaves the write pointer and full flag alone
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && load && !extract) |=> (full && $stable(wptr)))
        else $error("R3 load accepted while full");

    // R4: load with extract while full keeps full set
    p_full_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && load && extract) |=> full)
        else $error("R4 full dropped on swap");

    // R5: extract on empty does not move the read pointer
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && extract) |=> $stable(rptr))
        else $error("R5 read pointer moved while empty");

    // R7: a load into an empty FIFO clears empty on the next edge
    p_empty_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && load) |=> !empty)
        else $error("R7 empty stuck after load");

    // R8: load and extract in the middle keep the pointer distance
    p_mid_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && load && extract) |=> ((wptr - rptr) == $past(wptr - rptr)))
        else $error("R8 occupancy changed");

    // R6: flags never both set
    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full))
        else $error("R6 empty and full together");

endmodule

// File: tb/flop_fifo_tb.sv
module flop_fifo_tb;

    localparam int W  = 8;
    localparam int D  = 4;
    localparam int NV = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic         extract = 1'b0;
    logic [W-1:0] datain = '0;
    logic [W-1:0] dout_a, dout_s;
    logic         empty_a, full_a, empty_s, full_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [W-1:0] model [$];

    always #5 clk = ~clk;

    flop_fifo #(.WIDTH(W), .DEPTH(D), .AW(2), .ASYNC_RST(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .extract(extract),
        .datain(datain), .dataout(dout_a), .empty(empty_a), .full(full_a)
    );

    flop_fifo #(.WIDTH(W), .DEPTH(D), .AW(2), .ASYNC_RST(1'b0)) u_dut_sync (
        .clk(clk), .rst_n(rst_n), .load(load), .extract(extract),
        .datain(datain), .dataout(dout_s), .empty(empty_s), .full(full_s)
    );

    // row: {load, extract, datain, empty expected before, full expected before}
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h11, 1'b1, 1'b0},  // first load into empty (R7)
        {1'b1, 1'b1, 8'h22, 1'b0, 1'b0},  // mid swap (R8)
        {1'b1, 1'b0, 8'h33, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h44, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h55, 1'b0, 1'b0},  // fourth word fills (R6)
        {1'b1, 1'b0, 8'h66, 1'b0, 1'b1},  // refused load (R3)
        {1'b1, 1'b1, 8'h77, 1'b0, 1'b1},  // swap while full (R4)
        {1'b1, 1'b1, 8'h88, 1'b0, 1'b1},  // swap while full (R4)
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // last word out (R7)
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0},  // extract on empty (R5)
        {1'b1, 1'b1, 8'h99, 1'b1, 1'b0},  // pair on empty: load only (R5)
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Compare both instances against the queue model (state before this edge).
    task automatic compare_all();
        bit me;
        bit mf;
        me = (model.size() == 0);
        mf = (model.size() == D);
        chk(empty_a == me, "R7", "async empty", 32'(empty_a), 32'(me));
        chk(full_a  == mf, "R6", "async full",  32'(full_a),  32'(mf));
        chk(empty_s == me, "R7", "sync empty",  32'(empty_s), 32'(me));
        chk(full_s  == mf, "R6", "sync full",   32'(full_s),  32'(mf));
        if (!me) begin
            chk(dout_a == model[0], "R2", "async head", 32'(dout_a), 32'(model[0]));
            chk(dout_s == model[0], "R2", "sync head",  32'(dout_s), 32'(model[0]));
        end
    endtask

    task automatic model_edge(input bit ld, input bit ex, input logic [W-1:0] d);
        bit wr;
        bit rd;
        rd = ex && (model.size() > 0);
        wr = ld && ((model.size() < D) || ex);
        if (rd) void'(model.pop_front());
        if (wr) model.push_back(d);
    endtask

    task automatic step(input bit ld, input bit ex, input logic [W-1:0] d);
        @(negedge clk);
        load = ld; extract = ex; datain = d;
        #1;
        compare_all();
        @(posedge clk);
        model_edge(ld, ex, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        load = 1'b0; extract = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model.delete();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin : main
        logic [W-1:0] keep0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(empty_a == 1'b1 && full_a == 1'b0, "R1", "async flags in reset",
            {empty_a, full_a}, 32'h2);
        chk(empty_s == 1'b1 && full_s == 1'b0, "R1", "sync flags in reset",
            {empty_s, full_s}, 32'h2);
        rst_n = 1'b1;

        // Table walk: flags from the table, data from the queue model
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            load = VEC[i][11]; extract = VEC[i][10]; datain = VEC[i][9:2];
            #1;
            chk(empty_a == VEC[i][1], "R7", $sformatf("row %0d empty", i),
                32'(empty_a), 32'(VEC[i][1]));
            chk(full_a == VEC[i][0], "R6", $sformatf("row %0d full", i),
                32'(full_a), 32'(VEC[i][0]));
            compare_all();
            @(posedge clk);
            model_edge(VEC[i][11], VEC[i][10], VEC[i][9:2]);
        end

        // Random traffic with overflow and underflow attempts (R2 R3 R4 R5 R8)
        for (int n = 0; n < 600; n++) begin
            int bias;
            bias = (n / 100) % 3;
            step(($urandom % 4) < (bias == 0 ? 3 : 1) + (bias == 2 ? 1 : 0),
                 ($urandom % 4) < (bias == 1 ? 3 : 1) + (bias == 2 ? 1 : 0),
                 W'($urandom));
        end

        // R9: storage survives reset; slot 0 shows after reset
        do_reset();
        step(1'b1, 1'b0, 8'hA5);
        step(1'b1, 1'b0, 8'h3C);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        keep0 = 8'hA5;
        do_reset();
        #1;
        chk(dout_a == keep0, "R9", "async slot0 after reset", 32'(dout_a), 32'(keep0));
        chk(dout_s == keep0, "R9", "sync slot0 after reset",  32'(dout_s), 32'(keep0));
        chk(empty_a && empty_s, "R1", "empty after second reset",
            {empty_a, empty_s}, 32'h3);

        // R10: asynchronous versus clocked reset
        step(1'b1, 1'b0, 8'h5A);
        step(1'b1, 1'b0, 8'h6B);
        @(negedge clk);
        load = 1'b0; extract = 1'b0;
        #1;
        rst_n = 1'b0;
        #1;
        chk(empty_a == 1'b1, "R10", "async reset without edge", 32'(empty_a), 32'h1);
        chk(empty_s == 1'b0, "R10", "sync reset waits for edge", 32'(empty_s), 32'h0);
        @(posedge clk);
        #1;
        chk(empty_s == 1'b1, "R10", "sync reset after edge", 32'(empty_s), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        model.delete();

        // R6: exactly DEPTH loads raise full
        for (int k = 0; k < D; k++) step(1'b1, 1'b0, W'(8'hC0 + k));
        @(negedge clk);
        #1;
        chk(full_a && full_s, "R6", "full after DEPTH loads", {full_a, full_s}, 32'h3);
        compare_all();

        summary();
    end

endmodule